// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation structure held in memory, using 4 KB pages. A requester presents one address at a time, together with two attributes: whether the access is a store and whether it comes from user mode. The walker then reads the first-level (directory) entry through a memory read port. From that entry it forms the address of the second-level (table) entry and reads that entry too. It checks the presence and permission flags at both levels, and it writes the table entry back when the walk has to record a use or a modification.

The virtual address is split as follows:
- Bits 31..22 index the directory.
- Bits 21..12 index the table.
- Bits 11..0 are the byte offset within the page. They are carried into the physical address as they are.

Every entry is 4 bytes. Bits 31..12 of an entry hold a page frame number. The low bits are flags:
- bit 0: present
- bit 1: writable
- bit 2: user-accessible
- bit 5: used
- bit 6: modified

The response reports either the translated physical address or a fault code together with the level at which the fault arose.

Top module: `xlat_walker`

## Requirements
- R1: After a synchronous reset the walker is ready (`req_ready`=1) and drives no memory read, no memory write and no response.
- R2: Once a request is accepted, the first memory read is issued at address {`root_frame`, vaddr[31:22], 2'b00}, which is the directory base plus 4 times the directory index.
- R3: The table entry is read only after the directory entry data has returned. Its address is {directory entry[31:12], vaddr[21:12], 2'b00}.
- R4: A successful walk returns `resp_code`=2'b00 and the physical address {table entry[31:12], vaddr[11:0]}.
- R5: An entry whose bit 0 (present) is 0 ends the walk with `resp_code`=2'b01. `resp_level` is 0 for the directory and 1 for the table. A fault at the directory issues no table read.
- R6: A store (`req_write`=1) that meets an entry whose bit 1 (writable) is 0, at either level, ends the walk with `resp_code`=2'b10 and the level of that entry.
- R7: A user access (`req_user`=1) that meets an entry whose bit 2 (user-accessible) is 0, at either level, ends the walk with `resp_code`=2'b10. A supervisor access to such an entry is allowed.
- R8: On success, the table entry is written back to the address it was read from. The written value has bit 5 set, and bit 6 also set for a store. All other bits are unchanged.
- R9: No write-back happens when the entry already holds the bits R8 would set. No write-back happens on any fault.
- R10: From acceptance until the response, `req_ready` stays 0. `resp_valid` is high for exactly one cycle, and `req_ready` returns to 1 in the next cycle.
- R11: At a given level, an absent entry reports 2'b01 even when the access would also break that entry's permissions.
- R12: The walker waits for `mem_rd_valid` however many cycles the memory takes to answer a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_frame | input | 20 | Page frame number of the directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_user | input | 1 | Access comes from user mode |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_wr_en | output | 1 | One-cycle entry write-back |
| mem_addr | output | 32 | Byte address for the read or write |
| mem_wr_data | output | 32 | Entry value written back |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read from memory |
| resp_valid | output | 1 | Response valid for one cycle |
| resp_paddr | output | 32 | Physical address when `resp_code` is 2'b00 |
| resp_code | output | 2 | 00 success, 01 not present, 10 protection |
| resp_level | output | 1 | Level of a fault: 0 directory, 1 table |

## Verification
The in-RTL properties watch, on every cycle, that reads and writes never overlap and that an accepted request is followed at once by an aligned read. They also watch that the table read carries the table index of the held address, that any write-back sets the used bit (and the modified bit for stores), that a fault response is never preceded by a write, that the response lasts one cycle, and that the page offset is passed through unchanged. Several behaviours depend on what memory holds and can only be shown by the bench's scenarios against its behavioural reference model:
- the exact entry addresses
- the frame substitution
- which fault wins at which level
- the absence of a write-back for entries that already carry the bits
- tolerance of different read latencies

// File: rtl/xw_pkg.sv
`timescale 1ns/1ps
package xw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DIR  = 3'd1,
    ST_TBL  = 3'd2,
    ST_UPD  = 3'd3,
    ST_DONE = 3'd4,
    ST_FLT  = 3'd5
  } walk_st_e;

  typedef enum logic [1:0] {
    FC_NONE   = 2'b00,
    FC_ABSENT = 2'b01,
    FC_PROT   = 2'b10
  } fault_e;

  // flag positions inside an entry
  localparam int BIT_P   = 0;
  localparam int BIT_RW  = 1;
  localparam int BIT_US  = 2;
  localparam int BIT_ACC = 5;
  localparam int BIT_DRT = 6;

endpackage

// File: rtl/xw_addr_gen.sv
`timescale 1ns/1ps
// Forms an entry address: page-aligned frame base plus 4 * index.
module xw_addr_gen #(
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-OFF_W-1:0] frame,
  input  logic [IDX_W-1:0]        idx,
  output logic [ADDR_W-1:0]       addr
);
  localparam int PAD = OFF_W - IDX_W - 2;

  generate
    if (PAD > 0) begin : g_pad
      assign addr = {frame, {PAD{1'b0}}, idx, 2'b00};
    end else begin : g_tight
      assign addr = {frame, idx, 2'b00};
    end
  endgenerate
endmodule

// File: rtl/xw_entry_check.sv
`timescale 1ns/1ps
// Classifies one entry against the access: absence wins over permission.
module xw_entry_check
  import xw_pkg::*;
(
  input  logic [2:0] flags,      // {user-ok, writable, present}
  input  logic       is_write,
  input  logic       is_user,
  output fault_e     code
);
  always_comb begin
    code = FC_NONE;
    if (!flags[BIT_P]) begin
      code = FC_ABSENT;
    end else if ((is_write && !flags[BIT_RW]) || (is_user && !flags[BIT_US])) begin
      code = FC_PROT;
    end
  end
endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker
  import xw_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [2*IDX_W-1:0]               root_frame,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [2*IDX_W+OFF_W-1:0]         req_vaddr,
  input  logic                             req_write,
  input  logic                             req_user,
  output logic                             mem_rd_en,
  output logic                             mem_wr_en,
  output logic [2*IDX_W+OFF_W-1:0]         mem_addr,
  output logic [2*IDX_W+OFF_W-1:0]         mem_wr_data,
  input  logic                             mem_rd_valid,
  input  logic [2*IDX_W+OFF_W-1:0]         mem_rd_data,
  output logic                             resp_valid,
  output logic [2*IDX_W+OFF_W-1:0]         resp_paddr,
  output logic [1:0]                       resp_code,
  output logic                             resp_level
);
  localparam int ADDR_W = 2*IDX_W + OFF_W;
  localparam int FRM_W  = ADDR_W - OFF_W;
  localparam int LOW_W  = ADDR_W - IDX_W;   // table index + offset kept

  walk_st_e           st;
  fault_e             code_q;
  fault_e             chk_code;
  logic [LOW_W-1:0]   va_q;
  logic               wr_q;
  logic               usr_q;
  logic [ADDR_W-1:0]  dir_addr;
  logic [ADDR_W-1:0]  tbl_addr;
  logic [ADDR_W-1:0]  upd_ent;

  xw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) i_dir_addr (
    .frame (root_frame),
    .idx   (req_vaddr[ADDR_W-1 -: IDX_W]),
    .addr  (dir_addr)
  );

  xw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) i_tbl_addr (
    .frame (mem_rd_data[ADDR_W-1:OFF_W]),
    .idx   (va_q[LOW_W-1 -: IDX_W]),
    .addr  (tbl_addr)
  );

  xw_entry_check i_check (
    .flags    (mem_rd_data[2:0]),
    .is_write (wr_q),
    .is_user  (usr_q),
    .code     (chk_code)
  );

  always_comb begin
    upd_ent = mem_rd_data;
    upd_ent[BIT_ACC] = 1'b1;
    if (wr_q) upd_ent[BIT_DRT] = 1'b1;
  end

  assign req_ready = (st == ST_IDLE);
  assign resp_code = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      code_q      <= FC_NONE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_wr_en   <= 1'b0;
      mem_addr    <= '0;
      mem_wr_data <= '0;
      resp_valid  <= 1'b0;
      resp_paddr  <= '0;
      resp_level  <= 1'b0;
    end else begin
      mem_rd_en  <= 1'b0;
      mem_wr_en  <= 1'b0;
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q      <= req_vaddr[LOW_W-1:0];
            wr_q      <= req_write;
            usr_q     <= req_user;
            mem_addr  <= dir_addr;
            mem_rd_en <= 1'b1;
            st        <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (mem_rd_valid) begin
            if (chk_code != FC_NONE) begin
              code_q     <= chk_code;
              resp_level <= 1'b0;
              resp_paddr <= '0;
              resp_valid <= 1'b1;
              st         <= ST_FLT;
            end else begin
              mem_addr  <= tbl_addr;
              mem_rd_en <= 1'b1;
              st        <= ST_TBL;
            end
          end
        end
        ST_TBL: begin
          if (mem_rd_valid) begin
            if (chk_code != FC_NONE) begin
              code_q     <= chk_code;
              resp_level <= 1'b1;
              resp_paddr <= '0;
              resp_valid <= 1'b1;
              st         <= ST_FLT;
            end else begin
              resp_paddr <= {mem_rd_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
              if (upd_ent != mem_rd_data) begin
                mem_wr_en   <= 1'b1;
                mem_wr_data <= upd_ent;
              end
              st <= ST_UPD;
            end
          end
        end
        ST_UPD: begin
          code_q     <= FC_NONE;
          resp_level <= 1'b0;
          resp_valid <= 1'b1;
          st         <= ST_DONE;
        end
        default: st <= ST_IDLE;   // DONE and FLT: response cycle
      endcase
    end
  end

  // ---------------- properties ----------------
  p_first_read_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_rd_en && mem_addr[1:0] == 2'b00));

  p_tbl_index_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && st == ST_TBL) |-> (mem_addr[IDX_W+1:2] == va_q[LOW_W-1 -: IDX_W]));

  p_offset_r4: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_code == 2'b00) |-> (resp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

  p_wb_bits_r8: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_wr_data[BIT_ACC] && (mem_wr_data[BIT_DRT] || !wr_q)));

  p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  p_fault_no_wb_r9: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_code != 2'b00) |-> !$past(mem_wr_en));

  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> (!resp_valid && req_ready));

endmodule

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
module test_xlat_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] root_frame = 20'h00010;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wr_data;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic [1:0]  resp_code;
  logic        resp_level;

  always #2.5 clk = ~clk;

  xlat_walker i_xlat_walker (
    .clk, .rst, .root_frame, .req_valid, .req_ready, .req_vaddr, .req_write,
    .req_user, .mem_rd_en, .mem_wr_en, .mem_addr, .mem_wr_data, .mem_rd_valid,
    .mem_rd_data, .resp_valid, .resp_paddr, .resp_code, .resp_level
  );

  // behavioural memory and reference state
  bit [31:0] mem [bit [31:0]];
  bit [31:0] exp_rd[$];
  bit        exp_wr_pend;
  bit [31:0] exp_wr_addr, exp_wr_data;
  bit [1:0]  exp_code;
  bit        exp_level;
  bit [31:0] exp_paddr;
  bit        got_resp = 1'b0;
  bit        in_walk = 1'b0;
  string     cur_tag = "R1";
  int        rd_seen;
  int        lat = 1;
  int        cnt = 0;
  bit [31:0] pend_addr;
  int        n_chk = 0;
  int        n_fail = 0;
  int        cycles = 0;

  function automatic bit [31:0] rd_mem(bit [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, string what, bit [31:0] act, bit [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // per-clock comparison against the reference expectations, then memory model
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (in_walk && !got_resp)
        chk(req_ready == 1'b0, "R10", "ready while busy", {31'b0, req_ready}, 32'h0);
      if (mem_rd_en) begin
        if (exp_rd.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected read", mem_addr, 32'h0);
        end else begin
          bit [31:0] e;
          e = exp_rd.pop_front();
          chk(mem_addr == e, (rd_seen == 0) ? "R2" : "R3", "entry read address", mem_addr, e);
        end
        rd_seen++;
      end
      if (mem_wr_en) begin
        chk(exp_wr_pend, "R9", "unexpected write-back", mem_wr_data, 32'h0);
        if (exp_wr_pend) begin
          chk(mem_addr == exp_wr_addr, "R8", "write-back address", mem_addr, exp_wr_addr);
          chk(mem_wr_data == exp_wr_data, "R8", "write-back data", mem_wr_data, exp_wr_data);
        end
        exp_wr_pend = 1'b0;
        mem[mem_addr] = mem_wr_data;
      end
      if (resp_valid) begin
        if (got_resp) begin
          chk(1'b0, "R10", "second response", 32'h1, 32'h0);
        end else begin
          chk(resp_code == exp_code, cur_tag, "fault code", {30'b0, resp_code}, {30'b0, exp_code});
          if (exp_code != 2'b00)
            chk(resp_level == exp_level, cur_tag, "fault level", {31'b0, resp_level}, {31'b0, exp_level});
          else
            chk(resp_paddr == exp_paddr, "R4", "physical address", resp_paddr, exp_paddr);
        end
        got_resp = 1'b1;
      end
      // read responder with programmable latency (R12)
      mem_rd_valid = 1'b0;
      if (cnt != 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = rd_mem(pend_addr);
        end
      end
      if (mem_rd_en) begin
        pend_addr = mem_addr;
        cnt = lat;
      end
    end
  end

  // reference model from the requirements, then drive one request
  task automatic walk(bit [31:0] va, bit wr, bit usr, int l, string tag);
    bit [31:0] da, pde, ta, pte, nw;
    cur_tag = tag;
    lat = l;
    rd_seen = 0;
    exp_rd.delete();
    exp_wr_pend = 1'b0;
    exp_level = 1'b0;
    exp_paddr = 32'h0;
    da = {root_frame, va[31:22], 2'b00};
    pde = rd_mem(da);
    exp_rd.push_back(da);
    if (!pde[0]) exp_code = 2'b01;
    else if ((wr && !pde[1]) || (usr && !pde[2])) exp_code = 2'b10;
    else begin
      ta = {pde[31:12], va[21:12], 2'b00};
      pte = rd_mem(ta);
      exp_rd.push_back(ta);
      exp_level = 1'b1;
      if (!pte[0]) exp_code = 2'b01;
      else if ((wr && !pte[1]) || (usr && !pte[2])) exp_code = 2'b10;
      else begin
        exp_code = 2'b00;
        exp_paddr = {pte[31:12], va[11:0]};
        nw = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (nw != pte) begin
          exp_wr_pend = 1'b1;
          exp_wr_addr = ta;
          exp_wr_data = nw;
        end
      end
    end
    got_resp = 1'b0;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    in_walk = 1'b1;
    for (int i = 0; i < 80 && !got_resp; i++) @(posedge clk);
    in_walk = 1'b0;
    chk(got_resp, tag, "response seen", {31'b0, got_resp}, 32'h1);
    chk(exp_rd.size() == 0, "R3", "all entry reads issued", exp_rd.size(), 32'h0);
    chk(!exp_wr_pend, "R8", "write-back issued", {31'b0, exp_wr_pend}, 32'h0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after response", {31'b0, req_ready}, 32'h1);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    chk(1'b0, "R10", "watchdog expired", cycles, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // directory at 0x10000
    mem[32'h00010004] = 32'h00020007;  // dir 1: P RW US
    mem[32'h0002000C] = 32'h00ABC007;
    mem[32'h00020018] = 32'h00DEF006;  // absent table entry
    mem[32'h00020008] = 32'h00222005;  // read-only table entry
    mem[32'h00020020] = 32'h00444003;  // supervisor table entry
    mem[32'h0001000C] = 32'h00030005;  // dir 3: read-only
    mem[32'h00030004] = 32'h00111007;
    mem[32'h00010010] = 32'h00040003;  // dir 4: supervisor
    mem[32'h0004001C] = 32'h00333007;
    mem[32'h00010014] = 32'h00050004;  // dir 5: absent, RO, user
    mem[32'h00010FFC] = 32'h00060007;  // dir 1023
    mem[32'h00060FFC] = 32'hFFFFF007;
    mem[32'h00010000] = 32'h00070007;  // dir 0
    mem[32'h00070000] = 32'h00000067;  // already used and modified

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", {31'b0, req_ready}, 32'h1);
    chk(resp_valid == 1'b0, "R1", "no response after reset", {31'b0, resp_valid}, 32'h0);
    chk(!mem_rd_en && !mem_wr_en, "R1", "memory idle after reset", {30'b0, mem_rd_en, mem_wr_en}, 32'h0);

    walk(32'h00403123, 1'b0, 1'b1, 1, "R8");   // user load: set used bit
    walk(32'h00403123, 1'b1, 1'b1, 2, "R8");   // store: set modified bit
    walk(32'h00403123, 1'b0, 1'b1, 1, "R9");   // nothing to change
    walk(32'h00403123, 1'b1, 1'b0, 3, "R9");
    walk(32'h00805010, 1'b0, 1'b0, 1, "R5");   // directory absent
    walk(32'h00406ABC, 1'b0, 1'b0, 2, "R5");   // table absent
    walk(32'h00C01004, 1'b1, 1'b0, 1, "R6");   // store through RO directory
    walk(32'h00C01004, 1'b0, 1'b1, 1, "R4");   // load through RO directory
    walk(32'h00402008, 1'b1, 1'b1, 2, "R6");   // store to RO table entry
    walk(32'h00402008, 1'b0, 1'b1, 1, "R4");
    walk(32'h01007FFF, 1'b0, 1'b1, 1, "R7");   // user to supervisor directory
    walk(32'h01007FFF, 1'b1, 1'b0, 1, "R7");   // supervisor allowed
    walk(32'h00408000, 1'b0, 1'b1, 3, "R7");   // user to supervisor table entry
    walk(32'h00408000, 1'b0, 1'b0, 1, "R7");
    walk(32'h01400000, 1'b1, 1'b1, 2, "R11");  // absent wins over protection
    walk(32'hFFFFFFFF, 1'b0, 1'b0, 4, "R12");  // top indices, long latency
    walk(32'h00000000, 1'b1, 1'b1, 5, "R12");  // bottom indices, no write-back

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule